// File: doc/BRIEF.md
# Serial Code-Word Detector with Data-Word Capture

This block watches a serial bit stream, one bit per clock cycle in which the bit enable is high, for a programmed code word. The code word is 16 or 24 bits long. When the most recent bits equal the code word, the block takes in the next word of the same length and stores it in a receive register. It then raises a status flag, which stays high until a read strobe clears it.

From the moment the code word is found, the block replaces the bit stream it sends downstream with an alternating idle pattern for a selectable number of bit periods. The incoming data word therefore never reaches the downstream consumer. A bypass input turns detection off, and the stream then passes through unchanged. Decoding of a processor bus is left to the surrounding logic: the receive word and the status flag are plain outputs, and the read strobe is a plain input.

Top module: `cwd_capture`

## Requirements
- R1: Bits enter MSB-first. The first bit received ends up in the most significant position of the active width. A match occurs on the bit at which the last W received bits equal `code_word[W-1:0]`, where W is 16 when `len_sel`=0 and 24 when `len_sel`=1. In 16-bit mode, `code_word[23:16]` is ignored.
- R2: After a match, the next W enabled bits are written into `rx_data` on the edge of the W-th bit. The first of these bits lands in bit W-1, and in 16-bit mode bits 23:16 read zero.
- R3: `status` goes high on the same edge that loads `rx_data`, and never earlier.
- R4: A `rd_strobe` cycle clears `status` on the next edge and leaves `rx_data` unchanged. If a capture falls in the same cycle as a read, the capture wins and `status` stays high.
- R5: A capture while `status` is already high overwrites `rx_data`, and `status` remains high.
- R6: On the edge of the matching bit, `dout` still carries that bit. For the next N enabled bits, `dout` carries 1,0,1,0,… and then follows `din` again. N is set by `idle_sel`: 0→32, 1→40, 2→48, 3→48.
- R7: No match is looked for while a data word is being received. After the capture, the search starts again with a cleared history, so a data word that equals the code word does not trigger a new detection.
- R8: While `bypass` is high, `dout` takes `din` on every enabled bit. No match, capture or idle insertion takes place, although `rd_strobe` still clears `status`.
- R9: `dout` is a register that changes only on edges where `bit_en` is high. Between enabled bits it holds its value, and the idle pattern does not advance.
- R10: A synchronous `rst` clears the bit history, `rx_data`, `status`, the idle count and `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | One-cycle qualifier marking a new serial bit |
| din | input | 1 | Serial descrambled data |
| bypass | input | 1 | Disable detection, pass data through |
| len_sel | input | 1 | Word length: 0 = 16 bits, 1 = 24 bits |
| idle_sel | input | 2 | Idle length: 0 = 32, 1 = 40, 2/3 = 48 bits |
| code_word | input | 24 | Programmed code word (low 16 bits used in 16-bit mode) |
| rd_strobe | input | 1 | Read of the receive word; clears status |
| dout | output | 1 | Downstream serial bit |
| rx_data | output | 24 | Captured data word |
| status | output | 1 | Data word available |

## Verification
A table of code and data words is sent for both word lengths and all four idle selections. It includes codes with unused upper bits set to garbage, data words of all zeros and all ones, and a data word that equals the code word. The per-bit downstream check tells the three idle lengths apart and confirms that the pattern starts with a one. The data-equals-code vector shows that the search pauses during capture: a wrongful re-detection would restart the idle pattern after the expected end. Directed cases cover reads that meet a capture in the same cycle, back-to-back captures without a read, pauses in `bit_en` during idle, bypass, and a reset during idle.

// File: rtl/cwd_pkg.sv
package cwd_pkg;
   typedef enum logic {
      ST_SEARCH  = 1'b0,
      ST_CAPTURE = 1'b1
   } cwd_state_e;
endpackage

// File: rtl/cwd_shift_match.sv
// Bit history register and masked comparison against the code word.
module cwd_shift_match #(
   parameter int W    = 24,
   parameter int WMIN = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         bit_en,
   input  logic         din,
   input  logic         len_sel,
   input  logic [W-1:0] code_word,
   input  logic         clr,
   output logic [W-1:0] nxt_masked,
   output logic         hit
);
   logic [W-1:0] hist;
   logic [W-1:0] nxt;
   logic [W-1:0] mask;

   generate
      for (genvar i = 0; i < W; i++) begin : g_mask
         if (i < WMIN) begin : g_short
            assign mask[i] = 1'b1;
         end else begin : g_long
            assign mask[i] = len_sel;
         end
      end
   endgenerate

   assign nxt        = {hist[W-2:0], din};
   assign nxt_masked = nxt & mask;
   assign hit        = (nxt_masked == (code_word & mask));

   always_ff @(posedge clk) begin
      if (rst) begin
         hist <= '0;
      end else if (bit_en) begin
         hist <= clr ? '0 : nxt;
      end
   end
endmodule

// File: rtl/cwd_capture_ctrl.sv
// Search/capture sequencing, receive register and status flag.
module cwd_capture_ctrl
   import cwd_pkg::*;
#(
   parameter int W     = 24,
   parameter int WMIN  = 16,
   parameter int CNT_W = 5
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         bit_en,
   input  logic         bypass,
   input  logic         len_sel,
   input  logic         hit,
   input  logic [W-1:0] nxt_masked,
   input  logic         rd_strobe,
   output logic         detect,
   output logic         cap_load,
   output logic [W-1:0] rx_data,
   output logic         status
);
   localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(WMIN - 1);
   localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(W - 1);

   cwd_state_e       state;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last;
   logic             live;

   assign last     = len_sel ? LAST_LONG : LAST_SHORT;
   assign live     = bit_en & ~bypass;
   assign detect   = live & (state == ST_SEARCH) & hit;
   assign cap_load = live & (state == ST_CAPTURE) & (cnt == last);

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_SEARCH;
         cnt   <= '0;
      end else if (bypass) begin
         state <= ST_SEARCH;
         cnt   <= '0;
      end else if (detect) begin
         state <= ST_CAPTURE;
         cnt   <= '0;
      end else if (bit_en && state == ST_CAPTURE) begin
         if (cap_load) begin
            state <= ST_SEARCH;
            cnt   <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rx_data <= '0;
         status  <= 1'b0;
      end else begin
         if (cap_load) begin
            rx_data <= nxt_masked;
         end
         if (cap_load) begin
            status <= 1'b1;
         end else if (rd_strobe) begin
            status <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/cwd_idle_gen.sv
// Downstream bit register with alternating idle substitution.
module cwd_idle_gen #(
   parameter int IDLE_A = 32,
   parameter int IDLE_B = 40,
   parameter int IDLE_C = 48,
   parameter int IDLE_W = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bit_en,
   input  logic              din,
   input  logic              bypass,
   input  logic              detect,
   input  logic [1:0]        idle_sel,
   output logic              dout,
   output logic [IDLE_W-1:0] idle_cnt
);
   localparam logic [IDLE_W-1:0] LEN_A = IDLE_W'(IDLE_A);
   localparam logic [IDLE_W-1:0] LEN_B = IDLE_W'(IDLE_B);
   localparam logic [IDLE_W-1:0] LEN_C = IDLE_W'(IDLE_C);

   logic [IDLE_W-1:0] idle_len;
   logic              phase;

   always_comb begin
      case (idle_sel)
         2'd0:    idle_len = LEN_A;
         2'd1:    idle_len = LEN_B;
         default: idle_len = LEN_C;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         dout     <= 1'b0;
         idle_cnt <= '0;
         phase    <= 1'b1;
      end else if (bit_en) begin
         if (bypass) begin
            dout     <= din;
            idle_cnt <= '0;
            phase    <= 1'b1;
         end else if (detect) begin
            dout     <= din;
            idle_cnt <= idle_len;
            phase    <= 1'b1;
         end else if (idle_cnt != '0) begin
            dout     <= phase;
            phase    <= ~phase;
            idle_cnt <= idle_cnt - 1'b1;
         end else begin
            dout <= din;
         end
      end
   end
endmodule

// File: rtl/cwd_capture.sv
// Top: code-word detector with data-word capture and idle substitution.
module cwd_capture #(
   parameter int CW_MAX     = 24,
   parameter int CW_MIN     = 16,
   parameter int IDLE_A     = 32,
   parameter int IDLE_B     = 40,
   parameter int IDLE_C     = 48,
   parameter int IDLE_LIMIT = 48
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bit_en,
   input  logic              din,
   input  logic              bypass,
   input  logic              len_sel,
   input  logic [1:0]        idle_sel,
   input  logic [CW_MAX-1:0] code_word,
   input  logic              rd_strobe,
   output logic              dout,
   output logic [CW_MAX-1:0] rx_data,
   output logic              status
);
   localparam int CNT_W  = $clog2(CW_MAX);
   localparam int IDLE_W = $clog2(IDLE_LIMIT + 1);

   generate
      if (CW_MIN < 2 || CW_MIN >= CW_MAX) begin : g_bad_len
         $error("cwd_capture: CW_MIN must be at least 2 and below CW_MAX");
      end
      if (IDLE_A < CW_MAX || IDLE_B < CW_MAX || IDLE_C < CW_MAX) begin : g_bad_idle_min
         $error("cwd_capture: each idle length must cover a full data word");
      end
      if (IDLE_A > IDLE_LIMIT || IDLE_B > IDLE_LIMIT || IDLE_C > IDLE_LIMIT) begin : g_bad_idle_max
         $error("cwd_capture: idle length exceeds IDLE_LIMIT");
      end
   endgenerate

   logic [CW_MAX-1:0] nxt_masked;
   logic              hit;
   logic              detect;
   logic              cap_load;
   logic [IDLE_W-1:0] idle_cnt;

   cwd_shift_match #(.W(CW_MAX), .WMIN(CW_MIN)) u_match (
      .clk        (clk),
      .rst        (rst),
      .bit_en     (bit_en),
      .din        (din),
      .len_sel    (len_sel),
      .code_word  (code_word),
      .clr        (cap_load),
      .nxt_masked (nxt_masked),
      .hit        (hit)
   );

   cwd_capture_ctrl #(.W(CW_MAX), .WMIN(CW_MIN), .CNT_W(CNT_W)) u_ctrl (
      .clk        (clk),
      .rst        (rst),
      .bit_en     (bit_en),
      .bypass     (bypass),
      .len_sel    (len_sel),
      .hit        (hit),
      .nxt_masked (nxt_masked),
      .rd_strobe  (rd_strobe),
      .detect     (detect),
      .cap_load   (cap_load),
      .rx_data    (rx_data),
      .status     (status)
   );

   cwd_idle_gen #(
      .IDLE_A (IDLE_A),
      .IDLE_B (IDLE_B),
      .IDLE_C (IDLE_C),
      .IDLE_W (IDLE_W)
   ) u_idle (
      .clk      (clk),
      .rst      (rst),
      .bit_en   (bit_en),
      .din      (din),
      .bypass   (bypass),
      .detect   (detect),
      .idle_sel (idle_sel),
      .dout     (dout),
      .idle_cnt (idle_cnt)
   );
endmodule

// File: rtl/cwd_capture_chk.sv
// Protocol checker, attached to every cwd_capture instance.
module cwd_capture_chk #(
   parameter int W          = 24,
   parameter int IDLE_W     = 6,
   parameter int IDLE_LIMIT = 48
) (
   input logic              clk,
   input logic              rst,
   input logic              bit_en,
   input logic              din,
   input logic              bypass,
   input logic              rd_strobe,
   input logic              dout,
   input logic [W-1:0]      rx_data,
   input logic              status,
   input logic              detect,
   input logic              cap_load,
   input logic [IDLE_W-1:0] idle_cnt
);
   // R9
   assert_dout_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !bit_en |=> $stable(dout));
   // R8
   assert_bypass_pass_R8: assert property (@(posedge clk) disable iff (rst)
      (bit_en && bypass) |=> (dout == $past(din)));
   // R8
   assert_bypass_nodetect_R8: assert property (@(posedge clk) disable iff (rst)
      bypass |-> !(detect || cap_load));
   // R5
   assert_rx_stable_R5: assert property (@(posedge clk) disable iff (rst)
      !cap_load |=> $stable(rx_data));
   // R3
   assert_status_set_R3: assert property (@(posedge clk) disable iff (rst)
      cap_load |=> status);
   // R3
   assert_status_rise_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(status) |-> $past(cap_load));
   // R4
   assert_status_clear_R4: assert property (@(posedge clk) disable iff (rst)
      (rd_strobe && !cap_load) |=> !status);
   // R6
   assert_idle_first_R6: assert property (@(posedge clk) disable iff (rst)
      detect |=> (idle_cnt != '0));
   // R6
   assert_idle_bound_R6: assert property (@(posedge clk) disable iff (rst)
      32'(idle_cnt) <= IDLE_LIMIT);
endmodule

bind cwd_capture cwd_capture_chk #(
   .W          (CW_MAX),
   .IDLE_W     (IDLE_W),
   .IDLE_LIMIT (IDLE_LIMIT)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .bit_en    (bit_en),
   .din       (din),
   .bypass    (bypass),
   .rd_strobe (rd_strobe),
   .dout      (dout),
   .rx_data   (rx_data),
   .status    (status),
   .detect    (detect),
   .cap_load  (cap_load),
   .idle_cnt  (idle_cnt)
);

// File: tb/cwd_capture_test.sv
module cwd_capture_test;
   logic        clk = 1'b0;
   logic        rst = 1'b0;
   logic        bit_en = 1'b0;
   logic        din = 1'b0;
   logic        bypass = 1'b0;
   logic        len_sel = 1'b0;
   logic [1:0]  idle_sel = 2'd0;
   logic [23:0] code_word = '0;
   logic        rd_strobe = 1'b0;
   logic        dout;
   logic [23:0] rx_data;
   logic        status;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   cwd_capture uut (
      .clk       (clk),
      .rst       (rst),
      .bit_en    (bit_en),
      .din       (din),
      .bypass    (bypass),
      .len_sel   (len_sel),
      .idle_sel  (idle_sel),
      .code_word (code_word),
      .rd_strobe (rd_strobe),
      .dout      (dout),
      .rx_data   (rx_data),
      .status    (status)
   );

   // {len_sel, idle_sel, code_word, data_word}
   localparam logic [50:0] VEC [7] = '{
      {1'b0, 2'd0, 24'hA5A5C3, 24'h001234},
      {1'b1, 2'd0, 24'h9E3B71, 24'h5A0F3C},
      {1'b1, 2'd2, 24'hF00D42, 24'hFFFFFF},
      {1'b0, 2'd1, 24'h5A8001, 24'h000000},
      {1'b0, 2'd2, 24'h00FFFF, 24'h00BEEF},
      {1'b1, 2'd3, 24'h800000, 24'h000001},
      {1'b0, 2'd0, 24'h00A5C3, 24'h00A5C3}
   };

   task automatic chk(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; bit_en = 1'b0; rd_strobe = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   // one enabled bit; outputs are sampled at the following falling edge
   task automatic send_bit(input logic b, input logic rd);
      @(negedge clk);
      din = b; bit_en = 1'b1; rd_strobe = rd;
      @(negedge clk);
      bit_en = 1'b0; rd_strobe = 1'b0;
   endtask

   task automatic send_word(input logic [23:0] w, input int wl);
      for (int i = wl - 1; i >= 0; i--) send_bit(w[i], 1'b0);
   endtask

   task automatic run_vec(input logic [50:0] v);
      int wl, il;
      logic [23:0] code, data, expd;
      logic b, e;
      wl = v[50] ? 24 : 16;
      il = (v[49:48] == 2'd0) ? 32 : (v[49:48] == 2'd1) ? 40 : 48;
      code = v[47:24];
      data = v[23:0];
      expd = v[50] ? data : {8'h00, data[15:0]};
      do_reset();
      len_sel = v[50]; idle_sel = v[49:48]; code_word = code;
      for (int i = wl - 1; i >= 0; i--) begin
         send_bit(code[i], 1'b0);
         chk(dout === code[i], "R1 code bit passes", {23'd0, dout}, {23'd0, code[i]});
      end
      chk(status === 1'b0, "R3 no status at match", {23'd0, status}, 24'd0);
      for (int k = 1; k <= il + 4; k++) begin
         b = (k <= wl) ? data[wl - k] : 1'b0;
         send_bit(b, 1'b0);
         e = (k <= il) ? k[0] : b;
         chk(dout === e, "R6 idle pattern/resume (R7)", {23'd0, dout}, {23'd0, e});
         if (k == wl - 1) chk(status === 1'b0, "R3 status early", {23'd0, status}, 24'd0);
         if (k == wl) begin
            chk(status === 1'b1, "R3 status set", {23'd0, status}, 24'd1);
            chk(rx_data === expd, "R2 captured word", rx_data, expd);
         end
      end
      send_bit(1'b0, 1'b1);
      chk(status === 1'b0, "R4 read clears", {23'd0, status}, 24'd0);
      chk(rx_data === expd, "R4 read keeps data", rx_data, expd);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic d0;
      // R10 reset state
      do_reset();
      chk(dout === 1'b0 && status === 1'b0, "R10 reset outputs", {22'd0, dout, status}, 24'd0);
      chk(rx_data === 24'd0, "R10 reset rx", rx_data, 24'd0);

      foreach (VEC[n]) run_vec(VEC[n]);

      // R5 overwrite without read, then R4 capture beats read
      do_reset();
      len_sel = 1'b0; idle_sel = 2'd0; code_word = 24'h00C001;
      send_word(24'h00C001, 16); send_word(24'h001111, 16);
      send_word(24'h00C001, 16); send_word(24'h002222, 16);
      chk(status === 1'b1, "R5 status stays", {23'd0, status}, 24'd1);
      chk(rx_data === 24'h002222, "R5 overwrite", rx_data, 24'h002222);
      repeat (20) send_bit(1'b0, 1'b0);
      send_word(24'h00C001, 16);
      send_word(24'h003333 >> 1, 15);
      send_bit(1'b1, 1'b1);
      chk(status === 1'b1, "R4 capture wins over read", {23'd0, status}, 24'd1);
      chk(rx_data === 24'h003333, "R4 captured with read", rx_data, 24'h003333);

      // R8 bypass
      do_reset();
      bypass = 1'b1; code_word = 24'h00C001;
      for (int i = 15; i >= 0; i--) begin
         d0 = code_word[i];
         send_bit(d0, 1'b0);
         chk(dout === d0, "R8 bypass follows din", {23'd0, dout}, {23'd0, d0});
      end
      for (int i = 0; i < 20; i++) begin
         d0 = i[1];
         send_bit(d0, 1'b0);
         chk(dout === d0, "R8 bypass no idle", {23'd0, dout}, {23'd0, d0});
      end
      chk(status === 1'b0 && rx_data === 24'd0, "R8 no capture", rx_data, 24'd0);
      bypass = 1'b0;

      // R9 hold between enables, idle does not advance
      do_reset();
      send_word(24'h00C001, 16);
      send_bit(1'b0, 1'b0);
      chk(dout === 1'b1, "R6 idle starts with one", {23'd0, dout}, 24'd1);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         din = i[0];
      end
      @(negedge clk);
      chk(dout === 1'b1, "R9 hold without enable", {23'd0, dout}, 24'd1);
      send_bit(1'b1, 1'b0);
      chk(dout === 1'b0, "R9 pattern resumes", {23'd0, dout}, 24'd0);

      // R10 reset during idle clears the idle count
      do_reset();
      chk(dout === 1'b0, "R10 reset mid-idle", {23'd0, dout}, 24'd0);
      send_bit(1'b0, 1'b0);
      send_bit(1'b0, 1'b0);
      chk(dout === 1'b0, "R10 idle cleared", {23'd0, dout}, 24'd0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule